// File: doc/BRIEF.md
# Register Scoreboard with Dependent Wakeup

This block tracks, for every renamed physical register, whether its value has been produced, and for every instruction-queue entry, which of its two source operands are still waiting. When an instruction is placed in an entry, each source is resolved straight away when it is already known to be ready. This covers a ready flag supplied with the request, a tag outside the renamed range, a set scoreboard bit, or a completion of that same tag in the same cycle. Otherwise the entry is recorded as a waiter on that register. The instruction's destination register is marked as not produced.

A completion broadcast names a destination register. It sets that register's scoreboard bit, marks every recorded waiter's operand ready and empties the register's waiter set. When an entry's last missing operand arrives, the block raises a one-cycle pulse for that entry, which the issue logic uses as its wakeup. A squash names an entry: the entry is withdrawn only from the waiter sets of those sources that are still pending, and its ready bits are cleared. Placing a new producer on a register that still has waiters is reported on an error pulse. Entry allocation and issue selection are left to the surrounding queue.

Waiter sets are held as one bit vector per register over all (entry, source) slots. Every result is registered and appears one clock edge after the request that caused it.

Top module: `sb_wakeup`

## Requirements
- R1: After reset every source-ready bit, every ready pulse and the conflict output are 0, and no register counts as produced.
- R2: A dispatched source whose ready flag is 1, or whose tag is 16 (NUM_PREGS) or above, shows ready on the cycle after dispatch; such tags are never tracked.
- R3: A dispatched source whose ready flag is 0 but whose register has its scoreboard bit set shows ready on the cycle after dispatch.
- R4: A dispatched in-range source whose scoreboard bit is clear stays not ready until a completion of that tag. That completion sets the source ready on the following cycle for every waiter and sets the register's scoreboard bit. A ready source stays ready until its entry is squashed or dispatched again.
- R5: A completion in the same cycle as a dispatch whose source names the same in-range tag makes that source ready on the following cycle.
- R6: Dispatching with an in-range destination tag clears that register's scoreboard bit, so a later source on it waits. When a completion and a destination clear hit the same register in one cycle, the clear wins.
- R7: The ready pulse of entry e is high for exactly one cycle, on the cycle after the entry becomes valid with both sources ready. It also fires on the cycle after a dispatch into e that leaves both sources ready, even when e was already ready.
- R8: A squash of entry e clears both of its ready bits on the following cycle and removes it from the waiter sets of its pending sources. A later completion does not mark it, and a later producer on those registers reports no conflict. A dispatch to the same entry in the same cycle takes precedence over the squash.
- R9: Dispatching an in-range destination onto a register that still has a waiter (after that cycle's completion and squash) raises the conflict output for one cycle, on the cycle after the dispatch.
- R10: A completion with a tag of 16 or above changes no ready bit and raises no pulse.
- R11: After a completion, the register's waiter set is empty, so a new producer on it reports no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request this cycle |
| dispEntry | input | ENT_W | Queue entry receiving the instruction |
| dispSrc0Tag | input | TAG_W | First source register tag |
| dispSrc0Rdy | input | 1 | First source already known ready |
| dispSrc1Tag | input | TAG_W | Second source register tag |
| dispSrc1Rdy | input | 1 | Second source already known ready |
| dispDstTag | input | TAG_W | Destination register tag (at or above NUM_PREGS means none) |
| cmplValid | input | 1 | Completion broadcast this cycle |
| cmplTag | input | TAG_W | Register produced by the completing instruction |
| sqValid | input | 1 | Squash request this cycle |
| sqEntry | input | ENT_W | Entry to squash |
| src0Ready | output | NUM_ENTRIES | Per-entry first-source ready bits |
| src1Ready | output | NUM_ENTRIES | Per-entry second-source ready bits |
| issueReady | output | NUM_ENTRIES | One-cycle pulse per entry that became ready to issue |
| prodConflict | output | 1 | Pulse: a producer was placed on a register with waiters |

## Verification
Every output is a flop, so ready bits, ready pulses and the conflict flag are all due exactly one edge after the request cycle. This holds both for a completion waking a waiter and for a forward within a dispatch. The bench sets up a request after a falling edge and lets the rising edge take it. It advances its own expected state at that same edge and compares all outputs at the next falling edge. Directed sequences pin the forwarding, squash, conflict and redispatch corner cases with hand-derived values. A seeded random phase then compares every output on every cycle against the bench's model.

// File: rtl/sb_wakeup_pkg.sv
package sb_wakeup_pkg;

  // number of source operands per queue entry
  localparam int NSRC = 2;

  // strobes from the request decoder to the state datapath
  typedef struct packed {
    logic            dispWr;    // write a new entry
    logic [NSRC-1:0] srcWait;   // source must be recorded as a waiter
    logic            dstTrack;  // destination is a tracked register
    logic            cmplWr;    // completion of a tracked register
    logic            sqWr;      // withdraw an entry
  } sbStrobe_t;

endpackage

// File: rtl/sb_wakeup_ctrl.sv
module sb_wakeup_ctrl
  import sb_wakeup_pkg::*;
#(
  parameter int NUM_PREGS = 16,
  parameter int TAG_W     = 5
) (
  input  logic                       dispValid,
  input  logic [NSRC-1:0][TAG_W-1:0] srcTag,
  input  logic [NSRC-1:0]            srcFlag,
  input  logic [TAG_W-1:0]           dstTag,
  input  logic                       cmplValid,
  input  logic [TAG_W-1:0]           cmplTag,
  input  logic                       sqValid,
  input  logic [NSRC-1:0]            sbRd,
  output sbStrobe_t                  stb
);

  localparam logic [TAG_W:0] PREG_LIM = (TAG_W + 1)'(NUM_PREGS);

  function automatic logic tracked(input logic [TAG_W-1:0] tag);
    return ({1'b0, tag} < PREG_LIM);
  endfunction

  logic cmplHit;
  assign cmplHit = cmplValid && tracked(cmplTag);

  always_comb begin
    stb          = '0;
    stb.dispWr   = dispValid;
    stb.dstTrack = dispValid && tracked(dstTag);
    stb.cmplWr   = cmplHit;
    stb.sqWr     = sqValid;
    for (int s = 0; s < NSRC; s++) begin
      // a source waits only if nothing already proves it ready,
      // including a completion of the same tag in this cycle
      stb.srcWait[s] = dispValid && !srcFlag[s] && tracked(srcTag[s])
                       && !sbRd[s] && !(cmplHit && (cmplTag == srcTag[s]));
    end
  end

endmodule

// File: rtl/sb_wakeup_dp.sv
module sb_wakeup_dp
  import sb_wakeup_pkg::*;
#(
  parameter int NUM_PREGS   = 16,
  parameter int NUM_ENTRIES = 8,
  localparam int REG_W      = $clog2(NUM_PREGS),
  localparam int ENT_W      = $clog2(NUM_ENTRIES),
  localparam int NSLOT      = NUM_ENTRIES * NSRC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sbStrobe_t                  stb,
  input  logic [ENT_W-1:0]           dispEntry,
  input  logic [NSRC-1:0][REG_W-1:0] srcIdx,
  input  logic [REG_W-1:0]           dstIdx,
  input  logic [REG_W-1:0]           cmplIdx,
  input  logic [ENT_W-1:0]           sqEntry,
  output logic [NSRC-1:0]            sbRd,
  output logic [NSLOT-1:0]           rdyVec,
  output logic [NUM_ENTRIES-1:0]     pulseVec,
  output logic                       conflict
);

  // scoreboard: 1 = register value produced
  logic [NUM_PREGS-1:0]            sbQ, sbN;
  // waiter sets: one bit per (entry, source) slot for each register
  logic [NUM_PREGS-1:0][NSLOT-1:0] waitQ, waitN;
  // per-slot state
  logic [NSLOT-1:0]                rdyQ, rdyN;
  logic [NSLOT-1:0][REG_W-1:0]     tagQ, tagN;
  logic [NUM_ENTRIES-1:0]          valQ, valN;
  logic [NUM_ENTRIES-1:0]          pulseQ, pulseN;
  logic                            conflictQ, conflictN;

  // scoreboard lookup for the dispatch sources
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      sbRd[s] = 1'b0;
      for (int r = 0; r < NUM_PREGS; r++) begin
        if (srcIdx[s] == REG_W'(r)) sbRd[s] = sbQ[r];
      end
    end
  end

  always_comb begin
    sbN       = sbQ;
    waitN     = waitQ;
    rdyN      = rdyQ;
    tagN      = tagQ;
    valN      = valQ;
    conflictN = 1'b0;

    // 1) completion: wake all waiters, empty the set, mark produced
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (stb.cmplWr && (cmplIdx == REG_W'(r))) begin
        sbN[r]   = 1'b1;
        rdyN     = rdyN | waitQ[r];
        waitN[r] = '0;
      end
    end

    // 2) squash: withdraw only pending sources from their waiter sets
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (stb.sqWr && (sqEntry == ENT_W'(e))) begin
        valN[e] = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
          if (!rdyQ[e*NSRC+s]) begin
            for (int r = 0; r < NUM_PREGS; r++) begin
              if (tagQ[e*NSRC+s] == REG_W'(r)) waitN[r][e*NSRC+s] = 1'b0;
            end
          end
          rdyN[e*NSRC+s] = 1'b0;
        end
      end
    end

    // 3) producer placed on a register that still has waiters
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (stb.dstTrack && (dstIdx == REG_W'(r))) conflictN = |waitN[r];
    end

    // 4) dispatch: overwrite the entry, record its pending sources
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (stb.dispWr && (dispEntry == ENT_W'(e))) begin
        valN[e] = 1'b1;
        for (int s = 0; s < NSRC; s++) begin
          for (int r = 0; r < NUM_PREGS; r++) begin
            waitN[r][e*NSRC+s] = stb.srcWait[s] && (srcIdx[s] == REG_W'(r));
          end
          tagN[e*NSRC+s] = srcIdx[s];
          rdyN[e*NSRC+s] = !stb.srcWait[s];
        end
      end
    end

    // 5) destination clear wins over a same-cycle completion
    for (int r = 0; r < NUM_PREGS; r++) begin
      if (stb.dstTrack && (dstIdx == REG_W'(r))) sbN[r] = 1'b0;
    end
  end

  // ready-to-issue edge detection, re-armed by a dispatch into the entry
  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      pulseN[e] = valN[e] && (&rdyN[e*NSRC +: NSRC])
                  && (!(valQ[e] && (&rdyQ[e*NSRC +: NSRC]))
                      || (stb.dispWr && (dispEntry == ENT_W'(e))));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbQ       <= '0;
      waitQ     <= '0;
      rdyQ      <= '0;
      tagQ      <= '0;
      valQ      <= '0;
      pulseQ    <= '0;
      conflictQ <= 1'b0;
    end else begin
      sbQ       <= sbN;
      waitQ     <= waitN;
      rdyQ      <= rdyN;
      tagQ      <= tagN;
      valQ      <= valN;
      pulseQ    <= pulseN;
      conflictQ <= conflictN;
    end
  end

  assign rdyVec   = rdyQ;
  assign pulseVec = pulseQ;
  assign conflict = conflictQ;

endmodule

// File: rtl/sb_wakeup.sv
module sb_wakeup
  import sb_wakeup_pkg::*;
#(
  parameter int NUM_PREGS   = 16,
  parameter int TAG_W       = 5,
  parameter int NUM_ENTRIES = 8,
  localparam int ENT_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dispValid,
  input  logic [ENT_W-1:0]       dispEntry,
  input  logic [TAG_W-1:0]       dispSrc0Tag,
  input  logic                   dispSrc0Rdy,
  input  logic [TAG_W-1:0]       dispSrc1Tag,
  input  logic                   dispSrc1Rdy,
  input  logic [TAG_W-1:0]       dispDstTag,
  input  logic                   cmplValid,
  input  logic [TAG_W-1:0]       cmplTag,
  input  logic                   sqValid,
  input  logic [ENT_W-1:0]       sqEntry,
  output logic [NUM_ENTRIES-1:0] src0Ready,
  output logic [NUM_ENTRIES-1:0] src1Ready,
  output logic [NUM_ENTRIES-1:0] issueReady,
  output logic                   prodConflict
);

  localparam int REG_W = $clog2(NUM_PREGS);
  localparam int NSLOT = NUM_ENTRIES * NSRC;

  logic [NSRC-1:0][TAG_W-1:0] srcTag;
  logic [NSRC-1:0][REG_W-1:0] srcIdx;
  logic [NSRC-1:0]            srcFlag;
  logic [NSRC-1:0]            sbRd;
  logic [NSLOT-1:0]           rdyVec;
  sbStrobe_t                  stb;

  assign srcTag[0]  = dispSrc0Tag;
  assign srcTag[1]  = dispSrc1Tag;
  assign srcFlag[0] = dispSrc0Rdy;
  assign srcFlag[1] = dispSrc1Rdy;

  for (genvar s = 0; s < NSRC; s++) begin : g_idx
    assign srcIdx[s] = srcTag[s][REG_W-1:0];
  end

  sb_wakeup_ctrl #(
    .NUM_PREGS (NUM_PREGS),
    .TAG_W     (TAG_W)
  ) u_ctrl (
    .dispValid (dispValid),
    .srcTag    (srcTag),
    .srcFlag   (srcFlag),
    .dstTag    (dispDstTag),
    .cmplValid (cmplValid),
    .cmplTag   (cmplTag),
    .sqValid   (sqValid),
    .sbRd      (sbRd),
    .stb       (stb)
  );

  sb_wakeup_dp #(
    .NUM_PREGS   (NUM_PREGS),
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .dispEntry (dispEntry),
    .srcIdx    (srcIdx),
    .dstIdx    (dispDstTag[REG_W-1:0]),
    .cmplIdx   (cmplTag[REG_W-1:0]),
    .sqEntry   (sqEntry),
    .sbRd      (sbRd),
    .rdyVec    (rdyVec),
    .pulseVec  (issueReady),
    .conflict  (prodConflict)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_out
    assign src0Ready[e] = rdyVec[e*NSRC];
    assign src1Ready[e] = rdyVec[e*NSRC+1];
  end

endmodule

// File: rtl/sb_wakeup_chk.sv
module sb_wakeup_chk #(
  parameter int NUM_PREGS   = 16,
  parameter int TAG_W       = 5,
  parameter int NUM_ENTRIES = 8,
  localparam int ENT_W      = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dispValid,
  input logic [ENT_W-1:0]       dispEntry,
  input logic [TAG_W-1:0]       dispSrc0Tag,
  input logic                   dispSrc0Rdy,
  input logic                   sqValid,
  input logic [ENT_W-1:0]       sqEntry,
  input logic [NUM_ENTRIES-1:0] src0Ready,
  input logic [NUM_ENTRIES-1:0] src1Ready,
  input logic [NUM_ENTRIES-1:0] issueReady,
  input logic                   prodConflict
);

  localparam logic [TAG_W:0] PREG_LIM = (TAG_W + 1)'(NUM_PREGS);

  // R2: flagged or untracked first source is ready one cycle later
  p_disp_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid && (dispSrc0Rdy || ({1'b0, dispSrc0Tag} >= PREG_LIM))
    |=> src0Ready[$past(dispEntry)]);

  // R8: squash (without same-entry dispatch) clears both ready bits
  p_squash_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sqValid && !(dispValid && (dispEntry == sqEntry))
    |=> !src0Ready[$past(sqEntry)] && !src1Ready[$past(sqEntry)]);

  // R9: conflict only follows a dispatch
  p_conflict_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prodConflict |-> $past(dispValid));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    // R7: a pulse means both operands are ready
    p_pulse_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issueReady[e] |-> src0Ready[e] && src1Ready[e]);

    // R7: pulse lasts one cycle unless the entry is dispatched again
    p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      issueReady[e] && !(dispValid && (dispEntry == ENT_W'(e)))
      |=> !issueReady[e]);

    // R4: a ready source stays ready until squash or redispatch
    p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      src1Ready[e] && !(sqValid && (sqEntry == ENT_W'(e)))
      && !(dispValid && (dispEntry == ENT_W'(e)))
      |=> src1Ready[e]);
  end

endmodule

bind sb_wakeup sb_wakeup_chk #(
  .NUM_PREGS   (NUM_PREGS),
  .TAG_W       (TAG_W),
  .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dispValid    (dispValid),
  .dispEntry    (dispEntry),
  .dispSrc0Tag  (dispSrc0Tag),
  .dispSrc0Rdy  (dispSrc0Rdy),
  .sqValid      (sqValid),
  .sqEntry      (sqEntry),
  .src0Ready    (src0Ready),
  .src1Ready    (src1Ready),
  .issueReady   (issueReady),
  .prodConflict (prodConflict)
);

// File: tb/sb_wakeup_bench.sv
`timescale 1ns/1ps
module sb_wakeup_bench;

  localparam int NP    = 16;
  localparam int TW    = 5;
  localparam int NE    = 8;
  localparam int EW    = $clog2(NE);
  localparam int CLK_P = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dispValid = 1'b0;
  logic [EW-1:0] dispEntry = '0;
  logic [TW-1:0] dispSrc0Tag = '0, dispSrc1Tag = '0, dispDstTag = '0;
  logic          dispSrc0Rdy = 1'b0, dispSrc1Rdy = 1'b0;
  logic          cmplValid = 1'b0;
  logic [TW-1:0] cmplTag = '0;
  logic          sqValid = 1'b0;
  logic [EW-1:0] sqEntry = '0;
  logic [NE-1:0] src0Ready, src1Ready, issueReady;
  logic          prodConflict;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  done     = 1'b0;

  // bench model state
  bit [NP-1:0] sbM;
  bit [NE-1:0] valM, r0M, r1M, pulseM;
  int          t0M [NE];
  int          t1M [NE];
  bit          confM;

  always #(CLK_P/2) clk = ~clk;

  sb_wakeup #(.NUM_PREGS(NP), .TAG_W(TW), .NUM_ENTRIES(NE)) u_sb_wakeup (
    .clk(clk), .rst_n(rst_n),
    .dispValid(dispValid), .dispEntry(dispEntry),
    .dispSrc0Tag(dispSrc0Tag), .dispSrc0Rdy(dispSrc0Rdy),
    .dispSrc1Tag(dispSrc1Tag), .dispSrc1Rdy(dispSrc1Rdy),
    .dispDstTag(dispDstTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag),
    .sqValid(sqValid), .sqEntry(sqEntry),
    .src0Ready(src0Ready), .src1Ready(src1Ready),
    .issueReady(issueReady), .prodConflict(prodConflict)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit srcResolved(input bit flag, input int tag, input bit [NP-1:0] sbOld,
                                     input bit hit, input int ct);
    if (flag || tag >= NP) return 1'b1;
    if (sbOld[tag]) return 1'b1;
    return hit && (ct == tag);
  endfunction

  // advance the model by one edge using the request currently driven
  task automatic modelStep();
    bit [NP-1:0] sbOld = sbM;
    bit [NE-1:0] allOld;
    bit hit;
    int ct = int'(cmplTag);
    int de = int'(dispEntry);
    int dt = int'(dispDstTag);
    for (int e = 0; e < NE; e++) allOld[e] = valM[e] && r0M[e] && r1M[e];
    hit = cmplValid && (ct < NP);
    if (hit) begin
      for (int e = 0; e < NE; e++) begin
        if (valM[e] && !r0M[e] && t0M[e] == ct) r0M[e] = 1'b1;
        if (valM[e] && !r1M[e] && t1M[e] == ct) r1M[e] = 1'b1;
      end
      sbM[ct] = 1'b1;
    end
    if (sqValid) begin
      valM[sqEntry] = 1'b0; r0M[sqEntry] = 1'b0; r1M[sqEntry] = 1'b0;
    end
    confM = 1'b0;
    if (dispValid && dt < NP) begin
      for (int e = 0; e < NE; e++) begin
        if (valM[e] && !r0M[e] && t0M[e] == dt) confM = 1'b1;
        if (valM[e] && !r1M[e] && t1M[e] == dt) confM = 1'b1;
      end
    end
    if (dispValid) begin
      valM[de] = 1'b1;
      t0M[de]  = int'(dispSrc0Tag);
      t1M[de]  = int'(dispSrc1Tag);
      r0M[de]  = srcResolved(dispSrc0Rdy, t0M[de], sbOld, hit, ct);
      r1M[de]  = srcResolved(dispSrc1Rdy, t1M[de], sbOld, hit, ct);
      if (dt < NP) sbM[dt] = 1'b0;
    end
    for (int e = 0; e < NE; e++)
      pulseM[e] = valM[e] && r0M[e] && r1M[e] && (!allOld[e] || (dispValid && de == e));
  endtask

  task automatic idle();
    dispValid = 1'b0; cmplValid = 1'b0; sqValid = 1'b0;
  endtask

  task automatic disp(input int e, input int t0, input bit f0, input int t1, input bit f1, input int dst);
    dispValid = 1'b1; dispEntry = EW'(e);
    dispSrc0Tag = TW'(t0); dispSrc0Rdy = f0;
    dispSrc1Tag = TW'(t1); dispSrc1Rdy = f1;
    dispDstTag = TW'(dst);
  endtask

  task automatic cmpl(input int t);
    cmplValid = 1'b1; cmplTag = TW'(t);
  endtask

  task automatic squash(input int e);
    sqValid = 1'b1; sqEntry = EW'(e);
  endtask

  // one edge: request taken at posedge, outputs sampled at negedge
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    idle();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    sbM = '0; valM = '0; r0M = '0; r1M = '0; pulseM = '0; confM = 1'b0;
    for (int e = 0; e < NE; e++) begin t0M[e] = 0; t1M[e] = 0; end
    void'($urandom(32'd91357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 src0", 32'(src0Ready), 0);
    chk("R1 src1", 32'(src1Ready), 0);
    chk("R1 pulse", 32'(issueReady), 0);
    chk("R1 conflict", 32'(prodConflict), 0);

    cmpl(3); tick();
    // R3 in-flight catch, R2 untracked tag, R7 pulse
    disp(0, 3, 0, 20, 0, 31); tick();
    chk("R3 src0[0]", 32'(src0Ready[0]), 1);
    chk("R2 src1[0]", 32'(src1Ready[0]), 1);
    chk("R7 pulse[0]", 32'(issueReady), 32'h01);
    tick();
    chk("R7 pulse drops", 32'(issueReady), 0);

    disp(1, 5, 0, 9, 1, 6); tick();
    chk("R4 waits src0[1]", 32'(src0Ready[1]), 0);
    chk("R2 flag src1[1]", 32'(src1Ready[1]), 1);
    disp(2, 5, 0, 7, 0, 31); tick();
    chk("R4 waits e2", {30'd0, src1Ready[2], src0Ready[2]}, 0);
    disp(3, 30, 0, 1, 1, 5); tick();
    chk("R9 conflict", 32'(prodConflict), 1);
    chk("R7 pulse[3]", 32'(issueReady), 32'h08);

    cmpl(5); tick();
    chk("R4 wake src0", 32'(src0Ready), 32'h0F);
    chk("R7 pulse on wake", 32'(issueReady), 32'h02);
    chk("R9 conflict one cycle", 32'(prodConflict), 0);
    cmpl(20); tick();
    chk("R10 src0 unchanged", 32'(src0Ready), 32'h0F);
    chk("R10 src1 unchanged", 32'(src1Ready), 32'h0B);
    chk("R10 no pulse", 32'(issueReady), 0);

    squash(2); tick();
    chk("R8 squash clears", {30'd0, src1Ready[2], src0Ready[2]}, 0);
    disp(4, 31, 0, 31, 0, 7); tick();
    chk("R8 no conflict after squash", 32'(prodConflict), 0);
    cmpl(7); tick();
    chk("R8 src0 after completion", 32'(src0Ready), 32'h1B);
    chk("R8 src1 after completion", 32'(src1Ready), 32'h1B);

    disp(5, 25, 0, 25, 0, 3); tick();
    disp(6, 3, 0, 30, 0, 31); tick();
    chk("R6 cleared dest waits", 32'(src0Ready[6]), 0);
    disp(7, 9, 0, 31, 0, 31); cmpl(9); tick();
    chk("R5 forward", 32'(src0Ready[7]), 1);
    chk("R5 pulse[7]", 32'(issueReady), 32'h80);
    disp(2, 31, 0, 31, 0, 5); tick();
    chk("R11 no conflict after completion", 32'(prodConflict), 0);
    disp(2, 7, 0, 31, 0, 31); tick();
    chk("R4 produced register ready", 32'(src0Ready[2]), 1);
    chk("R7 redispatch pulse", 32'(issueReady[2]), 1);

    // random phase, checked against the model
    for (int i = 0; i < 3000; i++) begin
      dispValid   = ($urandom_range(9) < 6);
      dispEntry   = EW'($urandom_range(NE - 1));
      dispSrc0Tag = TW'($urandom_range(19));
      dispSrc1Tag = TW'($urandom_range(19));
      dispSrc0Rdy = ($urandom_range(3) == 0);
      dispSrc1Rdy = ($urandom_range(3) == 0);
      dispDstTag  = TW'($urandom_range(19));
      cmplValid   = ($urandom_range(9) < 4);
      cmplTag     = TW'($urandom_range(19));
      sqValid     = ($urandom_range(99) < 15);
      sqEntry     = EW'($urandom_range(NE - 1));
      tick();
      chk("R2/R3/R4/R5/R6/R8/R10 src0", 32'(src0Ready), 32'(r0M));
      chk("R2/R3/R4/R5/R6/R8/R10 src1", 32'(src1Ready), 32'(r1M));
      chk("R7 pulse", 32'(issueReady), 32'(pulseM));
      chk("R9/R11 conflict", 32'(prodConflict), 32'(confM));
    end

    finishRun();
  end

endmodule